// File: doc/BRIEF.md
# Single-Pass 4x4 Matrix Multiply-Accumulate Unit

This block computes D = A×B + C for square matrices of four rows and four columns in a single clock. Each operand matrix arrives complete on one wide port, as if it had been read from a register file in one access. The unit routes every element of A to the four products that need it, forms all 64 products at full precision in parallel, and then reduces each group of four products that share a row of A and a column of B. The matching C element is added to each group's sum.

A and B elements are narrow signed fixed-point values. C and D elements use a wider signed format, so that repeated accumulation keeps its precision. A single output register holds the result. A new operation can be issued on every clock, and its result appears one cycle later together with a valid flag. The block is meant to sit behind operand read ports in a compute lane. A sequencer can feed it back-to-back operations, or it can feed back D as the next C.

Top module: `mmac4x4_unit`

## Requirements
- R1: Element (i,j) of every packed port sits at bit offset (4·i + j)·W, where W is the element width. Elements are in row-major order, with (0,0) in the least significant bits. A and B elements are 16-bit two's complement, and C and D elements are 40-bit two's complement.
- R2: D(i,j) = C(i,j) + A(i,0)·B(0,j) + A(i,1)·B(1,j) + A(i,2)·B(2,j) + A(i,3)·B(3,j).
- R3: When valid_in is high at a rising edge with reset low, valid_out is high after that edge and d_out carries the result of the operands sampled at that edge.
- R4: Operations issued on consecutive cycles each produce their own correct result on consecutive cycles, with no bubble between them.
- R5: When valid_in is low at a rising edge with reset low, valid_out is low after that edge. d_out keeps its previous value whatever the operand ports carry.
- R6: Products are exact. In particular, -32768 × -32768 contributes +2^30.
- R7: The four-product sum always fits in 34 signed bits. D equals C plus that sum, reduced modulo 2^40 (two's complement wrap).
- R8: When every A element is zero, D equals C exactly.
- R9: A synchronous active-high reset clears valid_out and d_out to zero. Reset takes priority over a valid_in that is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands on a_in, b_in, c_in are to be processed this cycle |
| a_in | input | 256 | Matrix A, 16 signed 16-bit elements, row-major |
| b_in | input | 256 | Matrix B, 16 signed 16-bit elements, row-major |
| c_in | input | 640 | Addend matrix C, 16 signed 40-bit elements, row-major |
| valid_out | output | 1 | d_out holds a result produced on the previous cycle |
| d_out | output | 640 | Result matrix D, 16 signed 40-bit elements, row-major |

## Verification
Two of this block's functions can fall in the same cycle. First, the output register can present one result while it captures the next. The bench provokes this with long unbroken runs of operations, a new operand set on every cycle. Each cycle's output is judged against a three-deep loop model evaluated on the operands of the cycle before. Second, reset can coincide with a valid request. The bench drives both together, mid-stream and right after a run, and expects zeros rather than a computed result. Idle cycles carry random operands, and the bench confirms that the held D did not move.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
  localparam int unsigned DIM_DEF   = 4;
  localparam int unsigned OPW_DEF   = 16;
  localparam int unsigned ACCW_DEF  = 40;

  // Bit offset of element (row, col) in a row-major packed matrix.
  function automatic int unsigned elem_base(input int unsigned row,
                                            input int unsigned col,
                                            input int unsigned dim,
                                            input int unsigned width);
    return (row * dim + col) * width;
  endfunction

  // Index of the product that pairs A(row,k) with B(k,col).
  function automatic int unsigned prod_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned k,
                                             input int unsigned dim);
    return (row * dim + col) * dim + k;
  endfunction
endpackage

// File: rtl/mmac_operand_fanout.sv
module mmac_operand_fanout
  import mmac_pkg::*;
#(
  parameter int unsigned DIM = DIM_DEF,
  parameter int unsigned OPW = OPW_DEF,
  localparam int unsigned ELEMS = DIM * DIM,
  localparam int unsigned PRODS = DIM * DIM * DIM
) (
  input  logic [ELEMS*OPW-1:0] a_flat,
  input  logic [ELEMS*OPW-1:0] b_flat,
  output logic [PRODS*OPW-1:0] lhs_flat,
  output logic [PRODS*OPW-1:0] rhs_flat
);
  // Each A(r,k) is broadcast along columns; each B(k,c) along rows.
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      for (genvar k = 0; k < DIM; k++) begin : g_k
        localparam int unsigned P  = prod_index(r, c, k, DIM);
        localparam int unsigned AO = elem_base(r, k, DIM, OPW);
        localparam int unsigned BO = elem_base(k, c, DIM, OPW);
        assign lhs_flat[P*OPW +: OPW] = a_flat[AO +: OPW];
        assign rhs_flat[P*OPW +: OPW] = b_flat[BO +: OPW];
      end
    end
  end
endmodule

// File: rtl/mmac_mul_array.sv
module mmac_mul_array #(
  parameter int unsigned COUNT = 64,
  parameter int unsigned OPW   = 16,
  localparam int unsigned PW   = 2 * OPW
) (
  input  logic [COUNT*OPW-1:0] lhs_flat,
  input  logic [COUNT*OPW-1:0] rhs_flat,
  output logic [COUNT*PW-1:0]  prod_flat
);
  localparam logic [OPW-1:0] OP_MIN   = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [PW-1:0]  SQ_OFMIN = {2'b01, {(PW-2){1'b0}}};

  function automatic logic [PW-1:0] full_mul(input logic [OPW-1:0] x,
                                             input logic [OPW-1:0] y);
    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] ys;
    xs = PW'($signed(x));
    ys = PW'($signed(y));
    return PW'(xs * ys);
  endfunction

  for (genvar p = 0; p < COUNT; p++) begin : g_mul
    logic [OPW-1:0] x_w;
    logic [OPW-1:0] y_w;
    logic [PW-1:0]  prod_w;
    assign x_w    = lhs_flat[p*OPW +: OPW];
    assign y_w    = rhs_flat[p*OPW +: OPW];
    assign prod_w = full_mul(x_w, y_w);
    assign prod_flat[p*PW +: PW] = prod_w;

    always_comb begin
      if (x_w == OP_MIN && y_w == OP_MIN) begin
        // R6
        min_square_chk: assert (prod_w == SQ_OFMIN)
          else $error("most-negative square not exact");
      end
    end
  end
endmodule

// File: rtl/mmac_reduce_tree.sv
module mmac_reduce_tree
  import mmac_pkg::*;
#(
  parameter int unsigned DIM  = DIM_DEF,
  parameter int unsigned PW   = 2 * OPW_DEF,
  parameter int unsigned ACCW = ACCW_DEF,
  localparam int unsigned ELEMS = DIM * DIM,
  localparam int unsigned PRODS = DIM * DIM * DIM,
  localparam int unsigned DOTW  = PW + $clog2(DIM)
) (
  input  logic [PRODS*PW-1:0]   prod_flat,
  input  logic [ELEMS*ACCW-1:0] c_flat,
  output logic [ELEMS*ACCW-1:0] sum_flat
);
  localparam logic signed [DOTW-1:0] DOT_MAX = DOTW'(DIM) << (PW - 2);

  function automatic logic [ACCW-1:0] widen_add(input logic [DOTW-1:0] dot,
                                                input logic [ACCW-1:0] addend);
    logic [ACCW-1:0] ext;
    ext = {{(ACCW-DOTW){dot[DOTW-1]}}, dot};
    return addend + ext;
  endfunction

  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    logic [DIM*PW-1:0]   group_w;
    logic [DOTW-1:0]     dot_w;
    logic [ACCW-1:0]     c_w;
    logic [ACCW-1:0]     res_w;
    logic                group_zero_w;

    // Products of one output element are contiguous: stride-DIM grouping.
    assign group_w = prod_flat[e*DIM*PW +: DIM*PW];
    assign c_w     = c_flat[e*ACCW +: ACCW];

    always_comb begin
      dot_w = '0;
      for (int k = 0; k < DIM; k++) begin
        dot_w = dot_w + {{(DOTW-PW){group_w[k*PW+PW-1]}}, group_w[k*PW +: PW]};
      end
    end

    assign group_zero_w = (group_w == '0);
    assign res_w        = widen_add(dot_w, c_w);
    assign sum_flat[e*ACCW +: ACCW] = res_w;

    always_comb begin
      if (!$isunknown(group_w)) begin
        // R7
        dot_range_chk: assert ($signed(dot_w) <= DOT_MAX && $signed(dot_w) >= -DOT_MAX)
          else $error("dot product out of range");
      end
      if (group_zero_w && !$isunknown(c_w)) begin
        // R8
        zero_pass_chk: assert (res_w == c_w)
          else $error("zero products altered addend");
      end
    end
  end
endmodule

// File: rtl/mmac4x4_unit.sv
module mmac4x4_unit
  import mmac_pkg::*;
#(
  parameter int unsigned DIM  = DIM_DEF,
  parameter int unsigned OPW  = OPW_DEF,
  parameter int unsigned ACCW = ACCW_DEF,
  localparam int unsigned ELEMS = DIM * DIM,
  localparam int unsigned PRODS = DIM * DIM * DIM,
  localparam int unsigned PW    = 2 * OPW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_in,
  input  logic [ELEMS*OPW-1:0]  a_in,
  input  logic [ELEMS*OPW-1:0]  b_in,
  input  logic [ELEMS*ACCW-1:0] c_in,
  output logic                  valid_out,
  output logic [ELEMS*ACCW-1:0] d_out
);
  logic [PRODS*OPW-1:0]  lhs_w;
  logic [PRODS*OPW-1:0]  rhs_w;
  logic [PRODS*PW-1:0]   prod_w;
  logic [ELEMS*ACCW-1:0] sum_w;
  logic                  capture_w;

  assign capture_w = valid_in && !rst;

  mmac_operand_fanout #(.DIM(DIM), .OPW(OPW)) u_fanout (
    .a_flat  (a_in),
    .b_flat  (b_in),
    .lhs_flat(lhs_w),
    .rhs_flat(rhs_w)
  );

  mmac_mul_array #(.COUNT(PRODS), .OPW(OPW)) u_mul (
    .lhs_flat (lhs_w),
    .rhs_flat (rhs_w),
    .prod_flat(prod_w)
  );

  mmac_reduce_tree #(.DIM(DIM), .PW(PW), .ACCW(ACCW)) u_reduce (
    .prod_flat(prod_w),
    .c_flat   (c_in),
    .sum_flat (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      d_out     <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) d_out <= sum_w;
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_out && d_out == '0));

  // R3
  issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
    capture_w |=> valid_out);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> (!valid_out && $stable(d_out)));
endmodule

// File: tb/mmac4x4_unit_test.sv
module mmac4x4_unit_test;
  localparam int N = 4;
  localparam int OW = 16;
  localparam int CW = 40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              valid_in = 1'b0;
  logic [N*N*OW-1:0] a_in = '0;
  logic [N*N*OW-1:0] b_in = '0;
  logic [N*N*CW-1:0] c_in = '0;
  logic              valid_out;
  logic [N*N*CW-1:0] d_out;

  int vectors = 0;
  int miscompares = 0;
  logic              exp_v = 1'b0;
  logic [N*N*CW-1:0] exp_d = '0;

  always #4 clk = ~clk;

  mmac4x4_unit uut (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .valid_out(valid_out), .d_out(d_out)
  );

  // Reference model: plain triple loop in 64-bit integers.
  function automatic logic [N*N*CW-1:0] model(input logic [N*N*OW-1:0] a,
                                              input logic [N*N*OW-1:0] b,
                                              input logic [N*N*CW-1:0] c);
    logic [N*N*CW-1:0] d;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        longint acc;
        acc = longint'($signed(c[(i*N+j)*CW +: CW]));
        for (int k = 0; k < N; k++) begin
          acc += longint'($signed(a[(i*N+k)*OW +: OW])) *
                 longint'($signed(b[(k*N+j)*OW +: OW]));
        end
        d[(i*N+j)*CW +: CW] = acc[CW-1:0];
      end
    end
    return d;
  endfunction

  function automatic logic [N*N*OW-1:0] rnd_op();
    logic [N*N*OW-1:0] v;
    for (int e = 0; e < N*N; e++) v[e*OW +: OW] = OW'($urandom);
    return v;
  endfunction

  function automatic logic [N*N*CW-1:0] rnd_acc();
    logic [N*N*CW-1:0] v;
    for (int e = 0; e < N*N; e++) v[e*CW +: CW] = {8'($urandom), 32'($urandom)};
    return v;
  endfunction

  function automatic logic [N*N*OW-1:0] fill_op(input logic [OW-1:0] x);
    logic [N*N*OW-1:0] v;
    for (int e = 0; e < N*N; e++) v[e*OW +: OW] = x;
    return v;
  endfunction

  function automatic logic [N*N*CW-1:0] fill_acc(input logic [CW-1:0] x);
    logic [N*N*CW-1:0] v;
    for (int e = 0; e < N*N; e++) v[e*CW +: CW] = x;
    return v;
  endfunction

  // Drive one cycle at the falling edge, model the rising edge, sample at the next falling edge.
  task automatic step(input logic r, input logic v,
                      input logic [N*N*OW-1:0] a, input logic [N*N*OW-1:0] b,
                      input logic [N*N*CW-1:0] c, input string tag);
    rst = r; valid_in = v; a_in = a; b_in = b; c_in = c;
    @(posedge clk);
    if (r) begin
      exp_v = 1'b0; exp_d = '0;
    end else begin
      exp_v = v;
      if (v) exp_d = model(a, b, c);
    end
    @(negedge clk);
    vectors++;
    if (valid_out !== exp_v || d_out !== exp_d) begin
      miscompares++;
      $display("FAIL %s: valid_out=%0b d_out=%h expected valid=%0b d=%h",
               tag, valid_out, d_out, exp_v, exp_d);
    end
  endtask

  logic [N*N*OW-1:0] ident;
  logic [N*N*CW-1:0] seq_c;
  bit done = 0;

  initial begin
    ident = '0;
    for (int i = 0; i < N; i++) ident[(i*N+i)*OW +: OW] = 16'sd1;
    for (int e = 0; e < N*N; e++) seq_c[e*CW +: CW] = CW'(e * 1000 - 7000);

    @(negedge clk);
    // R9: reset with valid_in high still clears
    step(1, 1, rnd_op(), rnd_op(), rnd_acc(), "R9 reset over valid");
    step(1, 0, '0, '0, '0, "R9 reset idle");
    // R8: zero A passes C unchanged
    step(0, 1, '0, rnd_op(), rnd_acc(), "R8 zero A");
    // R1/R2: identity A gives B (sign-extended) plus C, checks placement
    step(0, 1, ident, rnd_op(), seq_c, "R1 identity placement");
    step(0, 1, rnd_op(), ident, seq_c, "R1 identity right");
    // R6: all most-negative, all most-positive, mixed
    step(0, 1, fill_op(16'h8000), fill_op(16'h8000), '0, "R6 min squared");
    step(0, 1, fill_op(16'h7FFF), fill_op(16'h7FFF), '0, "R6 max squared");
    step(0, 1, fill_op(16'h8000), fill_op(16'h7FFF), '0, "R6 min times max");
    // R7: wrap at the accumulator edge
    step(0, 1, fill_op(16'h8000), fill_op(16'h8000), fill_acc(40'h7F_FFFF_FFFF), "R7 positive wrap");
    step(0, 1, fill_op(16'h8000), fill_op(16'h7FFF), fill_acc(40'h80_0000_0000), "R7 negative wrap");
    // R5: idle cycles with garbage operands hold D
    for (int n = 0; n < 4; n++) step(0, 0, rnd_op(), rnd_op(), rnd_acc(), "R5 idle hold");
    // R4/R2/R3: long back-to-back random run
    for (int n = 0; n < 600; n++) step(0, 1, rnd_op(), rnd_op(), rnd_acc(), "R4 back-to-back");
    // R9: reset mid-stream with valid high, then resume
    step(1, 1, rnd_op(), rnd_op(), rnd_acc(), "R9 mid-stream reset");
    step(0, 1, fill_op(16'hFFFF), fill_op(16'h8000), fill_acc(40'hFF_FFFF_FFFF), "R3 first after reset");
    // R3/R5: alternating issue and idle
    for (int n = 0; n < 200; n++)
      step(0, n[0], rnd_op(), rnd_op(), rnd_acc(), "R3 alternating");
    // R6/R7: random extreme-element matrices
    for (int n = 0; n < 200; n++) begin
      logic [N*N*OW-1:0] xa, xb;
      for (int e = 0; e < N*N; e++) begin
        xa[e*OW +: OW] = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
        xb[e*OW +: OW] = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
      end
      step(0, 1, xa, xb, rnd_acc(), "R7 extreme mix");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule